// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block holds the digital state behind a single-channel 16-bit digital-to-analog converter. A serial front end hands it one 24-bit command word per completed transaction as a one-cycle strobe. The upper byte of the word carries an opcode and a channel number, and the lower 16 bits carry data. The block keeps three registers. The staging register receives newly written codes. The live register feeds the converter core through `active_code`. The setup register chooses power-down and clear behaviour.

A staged code reaches the live register in one of three ways: a write-and-update command, a separate load command, or the active-low load pin held low. A clear pin overrides everything else. A strap pin chooses mid-scale or zero as the value after reset. Read commands return the opcode byte and the chosen register on `rd_word`, and the serial front end reloads its shift register from that word, so the value comes out in the following transaction. Both pins pass through a synchronizer before they take effect.

Top module: `dbuf_dac_regctl`

## Requirements
- R1: While `rst` is high at a clock edge, the staging and live registers load 0x8000 if `pwrup_mid` is 1 and 0x0000 if it is 0. The setup register loads 0. After that edge, `amp_en` is 1, `pulldown_en` is 0 and `rd_valid` is 0.
- R2: Opcode 0x0 (command bits [23:20]) writes data bits [15:0] into the staging register only. `active_code` stays unchanged unless the load or clear pin is active.
- R3: Opcode 0x1 writes the data into both the staging register and the live register. `active_code` shows the new value right after the accepting edge.
- R4: Opcode 0x2 copies the staging register into the live register. Its data field is ignored.
- R5: While the synchronized `load_n` is low, the live register follows the staging register on every cycle, including a value written in that same cycle. The pin takes effect SYNC_STAGES+1 edges after it changes.
- R6: A command whose channel field (bits [18:16]) is not 0 changes no register and produces no `rd_valid`.
- R7: Opcodes 0x8, 0x9 and 0xA read the live, staging and setup register respectively. On the edge after the command, `rd_valid` pulses for one cycle and `rd_word` = {command byte, register value as it was before that edge}. The setup register is zero-extended to 16 bits.
- R8: Opcode 0x4 stores data bits [2:0] in the setup register. Bit 0 enables power-down. Bit 1 selects the power-down mode (1 = pull-down, 0 = high impedance). Bit 2 selects the clear value (1 = 0x8000, 0 = 0x0000).
- R9: One cycle after the setup register changes, `amp_en` = NOT bit 0 and `pulldown_en` = bit 0 AND bit 1. `pulldown_en` and `amp_en` are never both 1.
- R10: While the synchronized `clear_n` is low, both code registers are forced to the value chosen by setup bit 2. This overrides any write, load command or load pin in the same cycle.
- R11: Opcodes other than 0x0, 0x1, 0x2, 0x4, 0x8, 0x9 and 0xA change no register and produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrup_mid | input | 1 | Strap pin: 1 selects mid-scale after reset, 0 selects zero |
| load_n | input | 1 | Active-low, level-sensitive load pin (asynchronous) |
| clear_n | input | 1 | Active-low clear pin (asynchronous) |
| cmd_valid | input | 1 | One-cycle strobe: a complete command word is present |
| cmd_word | input | 24 | Command byte [23:16] followed by data [15:0] |
| active_code | output | 16 | Live register, drives the converter core |
| amp_en | output | 1 | Output amplifier enable |
| pulldown_en | output | 1 | Enables the internal pull-down termination |
| rd_valid | output | 1 | `rd_word` should be loaded into the shift register |
| rd_word | output | 24 | Read-back word: command byte and register value |

## Verification
The bench builds the block with a 16-bit code, a 3-bit channel field and a two-stage pin synchronizer. These are the values at which the opcode positions, the mid-scale value 0x8000 and the pin latency written in the requirements hold exactly. With two stages the bench can place a pin change and a command in the same cycle, and so reach the clear-versus-write and load-pin-versus-write collisions. The reference model counts the synchronizer delay itself rather than reading it from the design.

// File: rtl/dbdac_pkg.sv
package dbdac_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_WR_STAGE = 4'h0;
  localparam logic [OPC_W-1:0] OP_WR_BOTH  = 4'h1;
  localparam logic [OPC_W-1:0] OP_LOAD     = 4'h2;
  localparam logic [OPC_W-1:0] OP_WR_SETUP = 4'h4;
  localparam logic [OPC_W-1:0] OP_RD_LIVE  = 4'h8;
  localparam logic [OPC_W-1:0] OP_RD_STAGE = 4'h9;
  localparam logic [OPC_W-1:0] OP_RD_SETUP = 4'hA;

  localparam int SETUP_W   = 3;
  localparam int SU_PD_EN  = 0;
  localparam int SU_PD_PULL = 1;
  localparam int SU_CLR_MID = 2;

  typedef struct packed {
    logic wr_stage;
    logic wr_both;
    logic load;
    logic wr_setup;
    logic rd_live;
    logic rd_stage;
    logic rd_setup;
  } dec_t;
endpackage

// File: rtl/dbdac_pin_sync.sv
module dbdac_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/dbdac_cmd_decode.sv
module dbdac_cmd_decode
  import dbdac_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int VALID_CH = 0
) (
  input  logic             strobe,
  input  logic [OPC_W-1:0] opcode,
  input  logic [CH_W-1:0]  channel,
  output dec_t             dec
);
  localparam logic [CH_W-1:0] CH_OK = CH_W'(VALID_CH);

  logic hit;
  assign hit = strobe && (channel == CH_OK);

  always_comb begin
    dec = '0;
    if (hit) begin
      unique case (opcode)
        OP_WR_STAGE: dec.wr_stage = 1'b1;
        OP_WR_BOTH:  dec.wr_both  = 1'b1;
        OP_LOAD:     dec.load     = 1'b1;
        OP_WR_SETUP: dec.wr_setup = 1'b1;
        OP_RD_LIVE:  dec.rd_live  = 1'b1;
        OP_RD_STAGE: dec.rd_stage = 1'b1;
        OP_RD_SETUP: dec.rd_setup = 1'b1;
        default:     dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbdac_reg_bank.sv
module dbdac_reg_bank
  import dbdac_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwrup_mid,
  input  dec_t               dec,
  input  logic [CODE_W-1:0]  data,
  input  logic               ld_act,
  input  logic               clr_act,
  output logic [CODE_W-1:0]  stage_q,
  output logic [CODE_W-1:0]  live_q,
  output logic [SETUP_W-1:0] setup_q
);
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W-1);
  localparam logic [CODE_W-1:0] ZERO = '0;

  logic [CODE_W-1:0]  stage_d;
  logic [CODE_W-1:0]  live_d;
  logic [SETUP_W-1:0] setup_d;
  logic [CODE_W-1:0]  clr_val;

  assign clr_val = setup_q[SU_CLR_MID] ? MID : ZERO;

  always_comb begin
    stage_d = stage_q;
    live_d  = live_q;
    setup_d = setup_q;
    if (dec.wr_stage || dec.wr_both) stage_d = data;
    if (dec.wr_both)                 live_d  = data;
    if (dec.load)                    live_d  = stage_q;
    if (dec.wr_setup)                setup_d = data[SETUP_W-1:0];
    // level load passes the same-cycle write straight through
    if (ld_act)                      live_d  = stage_d;
    // clear wins over every other source
    if (clr_act) begin
      stage_d = clr_val;
      live_d  = clr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= pwrup_mid ? MID : ZERO;
      live_q  <= pwrup_mid ? MID : ZERO;
      setup_q <= '0;
    end else begin
      stage_q <= stage_d;
      live_q  <= live_d;
      setup_q <= setup_d;
    end
  end
endmodule

// File: rtl/dbdac_out_stage.sv
module dbdac_out_stage
  import dbdac_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int CMD_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dec_t                    dec,
  input  logic [CMD_W-1:0]        cmd_byte,
  input  logic [CODE_W-1:0]       stage_q,
  input  logic [CODE_W-1:0]       live_q,
  input  logic [SETUP_W-1:0]      setup_q,
  output logic                    amp_en,
  output logic                    pulldown_en,
  output logic                    rd_valid,
  output logic [CMD_W+CODE_W-1:0] rd_word
);
  logic [CODE_W-1:0] rd_sel;
  logic              rd_any;

  assign rd_any = dec.rd_live | dec.rd_stage | dec.rd_setup;

  always_comb begin
    rd_sel = '0;
    if (dec.rd_live)  rd_sel = live_q;
    if (dec.rd_stage) rd_sel = stage_q;
    if (dec.rd_setup) rd_sel = CODE_W'(setup_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_en      <= 1'b1;
      pulldown_en <= 1'b0;
      rd_valid    <= 1'b0;
      rd_word     <= '0;
    end else begin
      amp_en      <= ~setup_q[SU_PD_EN];
      pulldown_en <= setup_q[SU_PD_EN] & setup_q[SU_PD_PULL];
      rd_valid    <= rd_any;
      if (rd_any) rd_word <= {cmd_byte, rd_sel};
    end
  end
endmodule

// File: rtl/dbuf_dac_regctl.sv
module dbuf_dac_regctl
  import dbdac_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int CH_W        = 3,
  parameter int VALID_CH    = 0,
  parameter int SYNC_STAGES = 2,
  localparam int CMD_W      = OPC_W + 1 + CH_W,
  localparam int WORD_W     = CMD_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwrup_mid,
  input  logic              load_n,
  input  logic              clear_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output logic [CODE_W-1:0] active_code,
  output logic              amp_en,
  output logic              pulldown_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_word
);
  logic [CMD_W-1:0]   cmd_byte;
  logic [OPC_W-1:0]   opcode;
  logic [CH_W-1:0]    channel;
  logic [CODE_W-1:0]  data;
  logic [1:0]         pins_sync;
  logic               ld_act;
  logic               clr_act;
  dec_t               dec;
  logic [CODE_W-1:0]  stage_q;
  logic [CODE_W-1:0]  live_q;
  logic [SETUP_W-1:0] cfg_q;

  assign cmd_byte = cmd_word[WORD_W-1 -: CMD_W];
  assign opcode   = cmd_byte[CMD_W-1 -: OPC_W];
  assign channel  = cmd_byte[CH_W-1:0];
  assign data     = cmd_word[CODE_W-1:0];

  dbdac_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin_raw  ({clear_n, load_n}),
    .pin_sync (pins_sync)
  );

  assign ld_act  = ~pins_sync[0];
  assign clr_act = ~pins_sync[1];

  dbdac_cmd_decode #(.CH_W(CH_W), .VALID_CH(VALID_CH)) u_dec (
    .strobe  (cmd_valid),
    .opcode  (opcode),
    .channel (channel),
    .dec     (dec)
  );

  dbdac_reg_bank #(.CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .pwrup_mid (pwrup_mid),
    .dec       (dec),
    .data      (data),
    .ld_act    (ld_act),
    .clr_act   (clr_act),
    .stage_q   (stage_q),
    .live_q    (live_q),
    .setup_q   (cfg_q)
  );

  dbdac_out_stage #(.CODE_W(CODE_W), .CMD_W(CMD_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .dec         (dec),
    .cmd_byte    (cmd_byte),
    .stage_q     (stage_q),
    .live_q      (live_q),
    .setup_q     (cfg_q),
    .amp_en      (amp_en),
    .pulldown_en (pulldown_en),
    .rd_valid    (rd_valid),
    .rd_word     (rd_word)
  );

  assign active_code = live_q;
endmodule

// File: rtl/dbdac_chk.sv
module dbdac_chk
  import dbdac_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int CH_W   = 3,
  parameter int WORD_W = 24
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [WORD_W-1:0]  cmd_word,
  input logic [CODE_W-1:0]  active_code,
  input logic               amp_en,
  input logic               pulldown_en,
  input logic               rd_valid,
  input logic [WORD_W-1:0]  rd_word,
  input logic               ld_act,
  input logic               clr_act,
  input logic [SETUP_W-1:0] cfg_q
);
  localparam logic [CODE_W-1:0] MIDV = CODE_W'(1) << (CODE_W-1);
  localparam int CMD_W = WORD_W - CODE_W;

  logic [OPC_W-1:0] op;
  logic             ch_ok;
  logic             is_rd;
  assign op    = cmd_word[WORD_W-1 -: OPC_W];
  assign ch_ok = (cmd_word[CODE_W +: CH_W] == '0);
  assign is_rd = (op == OP_RD_LIVE) || (op == OP_RD_STAGE) || (op == OP_RD_SETUP);

  // R2
  stage_write_holds_live_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ch_ok && op == OP_WR_STAGE && !ld_act && !clr_act) |=> $stable(active_code));

  // R3
  write_both_live_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ch_ok && op == OP_WR_BOTH && !clr_act)
      |=> active_code == $past(cmd_word[CODE_W-1:0]));

  // R6
  foreign_channel_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !ch_ok) |=> !rd_valid);

  // R7
  read_returns_word_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && ch_ok && is_rd)
      |=> rd_valid && rd_word[WORD_W-1 -: CMD_W] == $past(cmd_word[WORD_W-1 -: CMD_W]));

  // R9
  pull_excludes_amp_chk: assert property (@(posedge clk) disable iff (rst)
    pulldown_en |-> !amp_en);

  // R10
  clear_forces_code_chk: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> active_code == ($past(cfg_q[SU_CLR_MID]) ? MIDV : '0));
endmodule

bind dbuf_dac_regctl dbdac_chk #(.CODE_W(CODE_W), .CH_W(CH_W), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_word    (cmd_word),
  .active_code (active_code),
  .amp_en      (amp_en),
  .pulldown_en (pulldown_en),
  .rd_valid    (rd_valid),
  .rd_word     (rd_word),
  .ld_act      (ld_act),
  .clr_act     (clr_act),
  .cfg_q       (cfg_q)
);

// File: tb/dbuf_dac_regctl_test.sv
module dbuf_dac_regctl_test;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwrup_mid = 1'b1;
  logic        load_n = 1'b1;
  logic        clear_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic [15:0] active_code;
  logic        amp_en, pulldown_en, rd_valid;
  logic [23:0] rd_word;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbuf_dac_regctl #(.CODE_W(16), .CH_W(3), .VALID_CH(0), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .pwrup_mid(pwrup_mid), .load_n(load_n), .clear_n(clear_n),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .active_code(active_code),
    .amp_en(amp_en), .pulldown_en(pulldown_en), .rd_valid(rd_valid), .rd_word(rd_word)
  );

  // behavioural reference model
  logic [15:0] m_in, m_act, m_rdc;
  logic [2:0]  m_cfg;
  logic        m_amp, m_pd, m_rdv;
  logic [23:0] m_rdw;
  int          ld_h[SYNC];
  int          cl_h[SYNC];

  always @(posedge clk) begin
    logic [15:0] ni, na, d;
    logic [2:0]  nc;
    logic [3:0]  op;
    logic [2:0]  ch;
    int ld, cl;
    if (rst) begin
      m_in  = pwrup_mid ? 16'h8000 : 16'h0000;
      m_act = m_in;
      m_cfg = 3'd0; m_amp = 1'b1; m_pd = 1'b0; m_rdv = 1'b0; m_rdw = '0;
      for (int i = 0; i < SYNC; i++) begin ld_h[i] = 1; cl_h[i] = 1; end
    end else begin
      ld = ld_h[SYNC-1]; cl = cl_h[SYNC-1];
      for (int i = SYNC-1; i > 0; i--) begin ld_h[i] = ld_h[i-1]; cl_h[i] = cl_h[i-1]; end
      ld_h[0] = int'(load_n); cl_h[0] = int'(clear_n);
      op = cmd_word[23:20]; ch = cmd_word[18:16]; d = cmd_word[15:0];
      ni = m_in; na = m_act; nc = m_cfg; m_rdv = 1'b0;
      if (cmd_valid && ch == 3'd0) begin
        case (op)
          4'h0: ni = d;
          4'h1: begin ni = d; na = d; end
          4'h2: na = m_in;
          4'h4: nc = d[2:0];
          4'h8: begin m_rdv = 1'b1; m_rdw = {cmd_word[23:16], m_act}; end
          4'h9: begin m_rdv = 1'b1; m_rdw = {cmd_word[23:16], m_in}; end
          4'hA: begin m_rdv = 1'b1; m_rdw = {cmd_word[23:16], 13'd0, m_cfg}; end
          default: ;
        endcase
      end
      if (ld == 0) na = ni;
      if (cl == 0) begin ni = m_cfg[2] ? 16'h8000 : 16'h0000; na = ni; end
      m_amp = !m_cfg[0];
      m_pd  = m_cfg[0] && m_cfg[1];
      m_in = ni; m_act = na; m_cfg = nc;
    end
  end

  task automatic chk(string what, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // compare against the model on every cycle, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("active_code", 24'(active_code), 24'(m_act));
      chk("amp_en", 24'(amp_en), 24'(m_amp));
      chk("pulldown_en", 24'(pulldown_en), 24'(m_pd));
      chk("rd_valid", 24'(rd_valid), 24'(m_rdv));
      chk("rd_word", rd_word, m_rdw);
      if (pulldown_en && amp_en) chk("R9 pull/amp exclusive", 24'd1, 24'd0);
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic send(logic [3:0] op, logic [2:0] ch, logic [15:0] d);
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_word = {op, 1'b0, ch, d};
    @(posedge clk); #2;
    cmd_valid = 1'b0; cmd_word = '0;
  endtask

  task automatic do_reset(logic mid);
    @(posedge clk); #2;
    rst = 1'b1; pwrup_mid = mid;
    tick(3);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired in %s", tag);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset values, both strap levels
    tag = "R1"; do_reset(1'b1); tick(1);
    chk("R1 mid reset code", 24'(active_code), 24'h8000);
    chk("R1 amp on", 24'(amp_en), 24'd1);
    do_reset(1'b0); tick(1);
    chk("R1 zero reset code", 24'(active_code), 24'h0000);
    chk("R1 no pulldown", 24'(pulldown_en), 24'd0);

    // R2 staging write only, R7 read back both code registers
    tag = "R2"; send(4'h0, 3'd0, 16'h1234);
    chk("R2 live unchanged", 24'(active_code), 24'h0000);
    tag = "R7"; send(4'h8, 3'd0, 16'hFFFF);
    chk("R7 read live", rd_word, 24'h800000);
    send(4'h9, 3'd0, 16'h0000);
    chk("R7 read staging", rd_word, 24'h901234);

    // R4 load command
    tag = "R4"; send(4'h2, 3'd0, 16'hDEAD);
    chk("R4 load copies staging", 24'(active_code), 24'h1234);

    // R3 write both
    tag = "R3"; send(4'h1, 3'd0, 16'hBEEF);
    chk("R3 live updated", 24'(active_code), 24'hBEEF);

    // R6 foreign channel
    tag = "R6"; send(4'h1, 3'd3, 16'h5555);
    chk("R6 write ignored", 24'(active_code), 24'hBEEF);
    send(4'h9, 3'd1, 16'h0000);
    chk("R6 read ignored", 24'(rd_valid), 24'd0);

    // R11 undefined opcodes
    tag = "R11"; send(4'h3, 3'd0, 16'h0101);
    send(4'hF, 3'd0, 16'h0202);
    chk("R11 no change", 24'(active_code), 24'hBEEF);
    send(4'h9, 3'd0, 16'h0000);
    chk("R11 staging kept", rd_word, 24'h90BEEF);

    // R8 setup write and readback, R9 output enables
    tag = "R8"; send(4'h4, 3'd0, 16'hFFFF);
    send(4'hA, 3'd0, 16'h0000);
    chk("R8 setup readback", rd_word, 24'hA00007);
    tag = "R9"; tick(1);
    chk("R9 pulldown on", 24'(pulldown_en), 24'd1);
    chk("R9 amp off", 24'(amp_en), 24'd0);
    send(4'h4, 3'd0, 16'h0001); tick(1);
    chk("R9 high impedance", 24'(pulldown_en), 24'd0);
    send(4'h4, 3'd0, 16'h0000); tick(1);
    chk("R9 amp back on", 24'(amp_en), 24'd1);

    // R5 level load pin
    tag = "R5"; send(4'h0, 3'd0, 16'h0F0F);
    load_n = 1'b0; tick(1);
    chk("R5 not yet synced", 24'(active_code), 24'hBEEF);
    tick(SYNC + 1);
    chk("R5 follows staging", 24'(active_code), 24'h0F0F);
    send(4'h0, 3'd0, 16'h7777);
    chk("R5 same-cycle write passes", 24'(active_code), 24'h7777);
    load_n = 1'b1; tick(SYNC + 2);
    send(4'h0, 3'd0, 16'h1111);
    chk("R5 released holds", 24'(active_code), 24'h7777);

    // R10 clear, priority over a colliding write
    tag = "R10"; send(4'h4, 3'd0, 16'h0004);
    clear_n = 1'b0; tick(SYNC);
    send(4'h1, 3'd0, 16'hAAAA);
    chk("R10 clear to mid beats write", 24'(active_code), 24'h8000);
    clear_n = 1'b1; tick(SYNC + 2);
    send(4'h9, 3'd0, 16'h0000);
    chk("R10 staging cleared", rd_word, 24'h908000);
    send(4'h4, 3'd0, 16'h0000);
    send(4'h1, 3'd0, 16'h4242);
    clear_n = 1'b0; tick(SYNC + 2);
    chk("R10 clear to zero", 24'(active_code), 24'h0000);
    clear_n = 1'b1; tick(SYNC + 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule